// File: doc/BRIEF.md
# Six-State Constrained Partial-Response Sequence Detector

This block recovers a bit stream from the equalized read-back samples of an extended class-4 partial-response channel. The recorded data is run-length limited and precoded so that every run of equal channel bits is at least two bits long. The sequence detector therefore never considers the two three-bit histories that would contain an isolated bit. It keeps six trellis states instead of eight. Four of them choose between two incoming branches. The other two have a single predecessor and only accumulate.

One signed sample is accepted on each clock in which `inValid` is high. The block computes a squared-distance metric for each of the five noiseless channel levels. It updates six path metrics, subtracts their minimum, and shifts the new decision bits into per-state survivor registers (register exchange). A detected bit leaves through `outBit` after a fixed decision depth. It is read from the survivor of the state whose metric is currently smallest. The encoder, decoder, precoder and equalizer sit outside the block.

Top module: `vit6_detector`

## Requirements
- R1: After reset `outValid` is 0 and `outBit` is 0. The detector assumes an all-zero bit history: the state coded 000 starts with metric 0 and every other state starts with a large penalty.
- R2: A state is the last three channel bits {b(k-2), b(k-1), b(k)}, with the newest bit in the least significant position. The noiseless sample for bit b(k) is UNIT·(b(k)+b(k-1)-b(k-2)-b(k-3)). For noiseless samples of any sequence whose runs are all at least two bits long, every bit is detected without error. Bit b(k) is on `outBit` after the clock edge that accepts sample k+DEPTH-1.
- R3: Detection stays error-free when each sample carries added noise of magnitude below UNIT/2.
- R4: A cycle with `inValid` low changes nothing in the detector. `outValid` is 0 after that edge, `outBit` keeps its value, and the sample value present in that cycle has no effect on later decisions.
- R5: `outValid` is high exactly in the cycle that follows an accepted sample whose index is DEPTH-1 or more. N accepted samples therefore produce N-DEPTH+1 output bits.
- R6: Runs of up to 40 equal bits are detected correctly, even though all-zero and all-one histories both give a zero channel level.
- R7: Path metrics are saturating unsigned values. After every step the smallest of the six is zero. The detector still decides correctly on clean input that follows full-scale samples far from any channel level.
- R8: Reset in the middle of a stream discards all history, and the following stream is detected as from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe; one trellis step per high cycle |
| sample | input | SAMPLE_W | Signed equalized sample, two's complement |
| outValid | output | 1 | `outBit` holds a new detected bit |
| outBit | output | 1 | Detected channel bit, DEPTH-1 samples behind the input |

## Verification
The hardest situation to reach is a long stretch of constant channel level. During it, a survivor in the all-ones state and one in the all-zeros state both gain zero per step, and the output must still come from the correct one. Table rows with run lengths up to 40 create these stretches. Bounded noise close to the UNIT/2 margin is added, and input bubbles interrupt the stream. The bubble cycles carry a full-scale sample that must be ignored. A directed burst of full-scale alternating samples drives the metrics far apart. Clean data follows it without reset to show that normalization lets the detector recover.

// File: rtl/vit6_pkg.sv
package vit6_pkg;

  localparam int NUM_STATES = 6;
  localparam int NUM_LEVELS = 5;

  typedef struct packed {
    logic step;
    logic emit;
  } ctrlStrobe_t;

  // index -> three-bit history {b(k-2), b(k-1), b(k)}
  function automatic logic [2:0] stateCode(input int idx);
    case (idx)
      0:       return 3'b000;
      1:       return 3'b001;
      2:       return 3'b011;
      3:       return 3'b100;
      4:       return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  function automatic bit isLegal(input logic [2:0] code);
    return (code != 3'b010) && (code != 3'b101);
  endfunction

  function automatic int codeToIdx(input logic [2:0] code);
    case (code)
      3'b000:  return 0;
      3'b001:  return 1;
      3'b011:  return 2;
      3'b100:  return 3;
      3'b110:  return 4;
      default: return 5;
    endcase
  endfunction

  // level index 0..4 stands for channel level -2..+2
  function automatic int levelIdx(input logic [2:0] prev, input logic newBit);
    return int'(newBit) + int'(prev[0]) - int'(prev[1]) - int'(prev[2]) + 2;
  endfunction

endpackage

// File: rtl/vit6_bmu.sv
module vit6_bmu
  import vit6_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int UNIT     = 32,
  parameter int BM_W     = 2 * (SAMPLE_W + 2)
) (
  input  logic signed [SAMPLE_W-1:0]           sample,
  output logic        [NUM_LEVELS-1:0][BM_W-1:0] levelMetric
);

  localparam int DW = SAMPLE_W + 2;

  // one squared distance per channel level, shared by all branches
  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
    localparam logic signed [DW-1:0] IDEAL = DW'((lv - 2) * UNIT);
    logic signed [DW-1:0]   diff;
    logic signed [BM_W-1:0] wide;
    assign diff = DW'(sample) - IDEAL;
    assign wide = BM_W'(diff);
    assign levelMetric[lv] = wide * wide;
  end

endmodule

// File: rtl/vit6_ctrl.sv
module vit6_ctrl
  import vit6_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] fillCnt;
  logic          filled;

  assign filled      = (fillCnt == CW'(DEPTH - 1));
  assign strobe.step = inValid;
  assign strobe.emit = inValid && filled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      if (inValid && !filled) fillCnt <= fillCnt + 1'b1;
    end
  end

endmodule

// File: rtl/vit6_datapath.sv
module vit6_datapath
  import vit6_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int UNIT     = 32,
  parameter int PM_W     = 20,
  parameter int DEPTH    = 12
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  ctrlStrobe_t                            strobe,
  input  logic signed [SAMPLE_W-1:0]             sample,
  output logic                                   outBit,
  output logic        [NUM_STATES-1:0][PM_W-1:0] pathMetric
);

  localparam int              BM_W    = 2 * (SAMPLE_W + 2);
  localparam logic [PM_W-1:0] PENALTY = PM_W'(1) << (PM_W - 2);

  logic [NUM_LEVELS-1:0][BM_W-1:0]  levelMetric;
  logic [NUM_STATES-1:0][PM_W-1:0]  pmQ, pmNew, pmNorm;
  logic [NUM_STATES-1:0][DEPTH-1:0] pathQ, pathNew;
  logic [PM_W-1:0]                  minVal;
  logic [2:0]                       bestIdx;

  vit6_bmu #(
    .SAMPLE_W(SAMPLE_W),
    .UNIT    (UNIT),
    .BM_W    (BM_W)
  ) u_bmu (
    .sample     (sample),
    .levelMetric(levelMetric)
  );

  function automatic logic [PM_W-1:0] satAdd(input logic [PM_W-1:0] pm,
                                             input logic [BM_W-1:0] bm);
    logic [PM_W:0] sum;
    sum = {1'b0, pm} + (PM_W + 1)'(bm);
    return sum[PM_W] ? '1 : sum[PM_W-1:0];
  endfunction

  for (genvar d = 0; d < NUM_STATES; d++) begin : g_node
    localparam logic [2:0] CODE    = stateCode(d);
    localparam logic [2:0] PRED_A  = {1'b0, CODE[2:1]};
    localparam logic [2:0] PRED_B  = {1'b1, CODE[2:1]};
    localparam bit         LEGAL_A = isLegal(PRED_A);
    localparam bit         LEGAL_B = isLegal(PRED_B);
    localparam int         IDX_A   = LEGAL_A ? codeToIdx(PRED_A) : 0;
    localparam int         IDX_B   = LEGAL_B ? codeToIdx(PRED_B) : 0;
    localparam int         LVL_A   = levelIdx(PRED_A, CODE[0]);
    localparam int         LVL_B   = levelIdx(PRED_B, CODE[0]);

    if (LEGAL_A && LEGAL_B) begin : g_acs
      logic [PM_W-1:0] candA, candB;
      logic            pickB;
      assign candA      = satAdd(pmQ[IDX_A], levelMetric[LVL_A]);
      assign candB      = satAdd(pmQ[IDX_B], levelMetric[LVL_B]);
      assign pickB      = candB < candA;
      assign pmNew[d]   = pickB ? candB : candA;
      assign pathNew[d] = pickB ? {pathQ[IDX_B][DEPTH-2:0], CODE[0]}
                                : {pathQ[IDX_A][DEPTH-2:0], CODE[0]};
    end else if (LEGAL_A) begin : g_addA
      assign pmNew[d]   = satAdd(pmQ[IDX_A], levelMetric[LVL_A]);
      assign pathNew[d] = {pathQ[IDX_A][DEPTH-2:0], CODE[0]};
    end else begin : g_addB
      assign pmNew[d]   = satAdd(pmQ[IDX_B], levelMetric[LVL_B]);
      assign pathNew[d] = {pathQ[IDX_B][DEPTH-2:0], CODE[0]};
    end

    assign pmNorm[d] = pmNew[d] - minVal;
  end

  always_comb begin
    minVal  = pmNew[0];
    bestIdx = 3'd0;
    for (int s = 1; s < NUM_STATES; s++) begin
      if (pmNew[s] < minVal) begin
        minVal  = pmNew[s];
        bestIdx = 3'(s);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STATES; s++) pmQ[s] <= (s == 0) ? '0 : PENALTY;
      pathQ  <= '0;
      outBit <= 1'b0;
    end else if (strobe.step) begin
      pmQ   <= pmNorm;
      pathQ <= pathNew;
      if (strobe.emit) outBit <= pathNew[bestIdx][DEPTH-1];
    end
  end

  assign pathMetric = pmQ;

endmodule

// File: rtl/vit6_detector.sv
module vit6_detector
  import vit6_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int UNIT     = 32,
  parameter int PM_W     = 20,
  parameter int DEPTH    = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       outValid,
  output logic                       outBit
);

  ctrlStrobe_t                     strobe;
  logic [NUM_STATES-1:0][PM_W-1:0] pathMetric;

  vit6_ctrl #(
    .DEPTH(DEPTH)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  vit6_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .UNIT    (UNIT),
    .PM_W    (PM_W),
    .DEPTH   (DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sample    (sample),
    .outBit    (outBit),
    .pathMetric(pathMetric)
  );

endmodule

// File: rtl/vit6_detector_chk.sv
module vit6_detector_chk
  import vit6_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int PM_W  = 20
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            inValid,
  input logic                            outValid,
  input logic                            outBit,
  input logic [NUM_STATES-1:0][PM_W-1:0] pathMetric
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] accCnt;
  logic          hasZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 accCnt <= '0;
    else if (inValid && accCnt != CW'(DEPTH))  accCnt <= accCnt + 1'b1;
  end

  always_comb begin
    hasZero = 1'b0;
    for (int s = 0; s < NUM_STATES; s++) if (pathMetric[s] == '0) hasZero = 1'b1;
  end

  // R4: an idle cycle produces no output and leaves the bit unchanged
  a_r4_idle_no_output: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r4_idle_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outBit));

  // R5: output strobe only after an accepted sample, and only once the window is full
  a_r5_needs_sample: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
  a_r5_fill_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (accCnt == CW'(DEPTH)));

  // R7: normalization keeps the best metric at zero
  a_r7_min_zero: assert property (@(posedge clk) disable iff (!rstN)
    hasZero);

endmodule

bind vit6_detector vit6_detector_chk #(
  .DEPTH(DEPTH),
  .PM_W (PM_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .outValid  (outValid),
  .outBit    (outBit),
  .pathMetric(pathMetric)
);

// File: tb/vit6_detector_tb.sv
module vit6_detector_tb;

  localparam int SAMPLE_W = 8;
  localparam int UNIT     = 32;
  localparam int PM_W     = 20;
  localparam int DEPTH    = 12;

  typedef struct packed {
    logic [15:0] seed;
    logic [7:0]  nBits;
    logic [3:0]  noiseAmp;
    logic [3:0]  gapEvery;
    logic [5:0]  maxRun;
    logic [1:0]  reqSel;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'hACE1, 8'd160, 4'd0, 4'd0, 6'd5,  2'd0},
    '{16'h1234, 8'd120, 4'd0, 4'd3, 6'd6,  2'd0},
    '{16'hBEEF, 8'd160, 4'd4, 4'd0, 6'd5,  2'd1},
    '{16'h0F0F, 8'd140, 4'd7, 4'd4, 6'd5,  2'd1},
    '{16'h5A5A, 8'd150, 4'd0, 4'd0, 6'd40, 2'd2},
    '{16'hC3C3, 8'd150, 4'd6, 4'd5, 6'd40, 2'd2}
  };

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic                       inValid = 1'b0;
  logic signed [SAMPLE_W-1:0] sample = '0;
  logic                       outValid;
  logic                       outBit;

  int checks = 0;
  int fails  = 0;
  bit seqBits [0:511];
  int nSeq;

  always #10 clk = ~clk;

  vit6_detector #(
    .SAMPLE_W(SAMPLE_W), .UNIT(UNIT), .PM_W(PM_W), .DEPTH(DEPTH)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sample(sample),
    .outValid(outValid), .outBit(outBit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrNext(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  // runs of equal bits, each at least two long, then a zero flush
  task automatic genSeq(input logic [15:0] seed, input int nBits, input int maxRun);
    logic [15:0] r = seed;
    bit cur = 1'b1;
    nSeq = 0;
    while (nSeq < nBits) begin
      int len;
      r   = lfsrNext(r);
      len = 2 + int'(r % 16'(maxRun - 1));
      for (int j = 0; j < len; j++) begin
        seqBits[nSeq] = cur;
        nSeq++;
      end
      cur = !cur;
    end
    for (int j = 0; j < DEPTH + 2; j++) begin
      seqBits[nSeq] = 1'b0;
      nSeq++;
    end
  endtask

  task automatic doReset(input string req);
    @(negedge clk);
    rstN    = 1'b0;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check(outValid == 1'b0, req, "outValid after reset", int'(outValid), 0);
    check(outBit == 1'b0,   req, "outBit after reset",   int'(outBit),   0);
  endtask

  task automatic runStream(input vec_t v, input string tag);
    logic [15:0] nz = ~v.seed;
    int i = 0, cyc = 0, acc = 0, outIdx = 0;
    bit prevAcc = 1'b0;
    bit h1 = 0, h2 = 0, h3 = 0;
    logic lastBit;
    genSeq(v.seed, int'(v.nBits), int'(v.maxRun));
    lastBit = outBit;
    forever begin
      bit expV;
      @(negedge clk);
      expV = prevAcc && (acc >= DEPTH);
      check(outValid == expV, "R5", "outValid", int'(outValid), int'(expV));
      if (!prevAcc)
        check(outBit == lastBit, "R4", "outBit held over idle cycle", int'(outBit), int'(lastBit));
      if (outValid && expV) begin
        check(outBit == seqBits[outIdx], tag, "detected bit", int'(outBit), int'(seqBits[outIdx]));
        outIdx++;
      end
      lastBit = outBit;
      if (i == nSeq) break;
      if (v.gapEvery != 0 && (cyc % int'(v.gapEvery)) == int'(v.gapEvery) - 1) begin
        inValid = 1'b0;
        sample  = 8'sd127;
        prevAcc = 1'b0;
      end else begin
        int lvl, noise, s;
        bit b = seqBits[i];
        lvl = int'(b) + int'(h1) - int'(h2) - int'(h3);
        nz  = lfsrNext(nz);
        noise = (v.noiseAmp == 0) ? 0
              : int'(nz % 16'(2 * int'(v.noiseAmp) + 1)) - int'(v.noiseAmp);
        s = lvl * UNIT + noise;
        sample  = SAMPLE_W'(s);
        inValid = 1'b1;
        h3 = h2; h2 = h1; h1 = b;
        prevAcc = 1'b1;
        acc++;
        i++;
      end
      cyc++;
    end
    inValid = 1'b0;
    check(outIdx == nSeq - DEPTH + 1, "R5", "output count", outIdx, nSeq - DEPTH + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset("R1");

    // table walk: R2 noiseless, R3 noisy, R6 long runs; gaps exercise R4
    for (int c = 0; c < NV; c++) begin
      string tag;
      tag = (VECS[c].reqSel == 2'd0) ? "R2" : (VECS[c].reqSel == 2'd1) ? "R3" : "R6";
      doReset("R1");
      runStream(VECS[c], tag);
    end

    // R7: full-scale garbage, then clean zeros without reset
    doReset("R1");
    for (int g = 0; g < 30; g++) begin
      @(negedge clk);
      inValid = 1'b1;
      sample  = (g % 2 == 0) ? 8'sd127 : -8'sd128;
    end
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (j >= DEPTH + 4) begin
        check(outValid == 1'b1, "R7", "outValid after garbage", int'(outValid), 1);
        check(outBit == 1'b0,   "R7", "bit after garbage",      int'(outBit),   0);
      end
      inValid = 1'b1;
      sample  = '0;
    end

    // R8: reset in mid-stream, then a fresh noisy stream
    doReset("R8");
    runStream(VECS[2], "R8");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule